// File: doc/BRIEF.md
# Fixed-Vector Interrupt Capture Unit

This block sits in front of a small 8-bit processor core. It gathers five interrupt request lines and picks one winner by fixed priority. It then turns that winner into a 16-bit vector address.

The five lines are:
- one non-maskable trap;
- three maskable lines (half-step 5.5, 6.5 and 7.5) whose vectors are fixed 4 bytes above an 8-byte restart slot;
- one general line, whose vector comes from a restart opcode byte presented by the interrupting device when the request is acknowledged.

Each line first passes through a two-flop synchronizer. It is then captured by one of three mechanisms, chosen per line by parameter:
- a plain level;
- a rising edge recorded in a sticky bit;
- a rising edge that must then stay high for a qualifying number of cycles.

The core sees a single request output. It answers with a one-cycle acknowledge and gets back a vector strobe in the following cycle. At the same time the global enable drops, and the sticky bit of the serviced source is cleared. A 4-bit mask register and a raw pending readout let firmware hold off lines without losing edges.

Top module: `irq_vector_unit`

## Requirements
- R1: Every request line passes through two synchronizer flops: a level line driven high just before clock edge k shows in `pending` after edge k+1 and not after edge k.
- R2: A level-captured line (default: 5.5 and 6.5, and the general line) is pending exactly while its synchronized input is high and stops being pending once the input is released.
- R3: An edge-captured line (default: 7.5) sets a sticky pending bit on a rising edge even while masked or while the global enable is low. The bit stays set until that source wins an acknowledge, and only then clears.
- R4: A hybrid-captured line (default: trap) becomes pending only when, after a rising edge, its synchronized input stays high for QUAL_CYCLES consecutive cycles (default 4). A shorter pulse leaves nothing pending. The bit is sticky until acknowledged.
- R5: Fixed vectors: trap 0x0024, 5.5 0x002C, 6.5 0x0034, 7.5 0x003C, with `vec_is_rst` high.
- R6: For the general line, an acknowledge opcode of the form 11nnn111 yields vector n*8 with `vec_is_rst` high. Any other opcode yields vector 0x0000 with `vec_is_rst` low.
- R7: Among eligible requests the winner is trap, then 7.5, then 6.5, then 5.5, then general.
- R8: The trap is eligible whenever it is pending, regardless of mask bits and of the global enable.
- R9: A maskable source is eligible only when pending, when its mask bit is 0, and when the global enable is 1. Mask bit positions: [0] general, [1] 5.5, [2] 6.5, [3] 7.5; a 1 blocks. `gie_set` raises the enable, and any granted acknowledge clears it.
- R10: An acknowledge while `irq_out` is high produces `vec_valid` for exactly one cycle, starting at the clock edge after the acknowledge. An acknowledge with nothing eligible produces no strobe.
- R11: After reset, `pending` is 0, the mask is 4'hF, the global enable is 0, and `irq_out` and `vec_valid` are low. `pending` bit order is [0] general, [1] 5.5, [2] 6.5, [3] 7.5, [4] trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_gen | input | 1 | General request line |
| req_hs | input | 3 | Half-step requests: [0] 5.5, [1] 6.5, [2] 7.5 |
| req_trap | input | 1 | Non-maskable trap request |
| ack | input | 1 | Acknowledge pulse from the core |
| ack_opcode | input | 8 | Opcode byte supplied for the general line on acknowledge |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 4 | New mask value (1 blocks a source) |
| gie_set | input | 1 | Raises the global enable |
| irq_out | output | 1 | Some source is eligible |
| pending | output | 5 | Captured requests before masking |
| mask_q | output | 4 | Current mask register |
| gie_q | output | 1 | Current global enable |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec_addr | output | 16 | Vector address |
| vec_is_rst | output | 1 | Vector came from a fixed slot or a restart opcode |

## Verification
The bench uses the default parameters. These give all three capture mechanisms on one instance: level on 5.5, 6.5 and general, sticky edge on 7.5, and the hybrid on the trap. With QUAL_CYCLES at 4, a 3-cycle trap pulse can be compared against a 4-cycle one, which probes the exact boundary of the qualification window. Holding several lines at once while acknowledging repeatedly walks the whole priority chain. The same sequence also covers every fixed vector and several opcode values on the general line.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   typedef enum logic [1:0] {CAP_LEVEL, CAP_EDGE, CAP_HYBRID} cap_mode_e;

   localparam int unsigned NSRC     = 5;
   localparam int unsigned SRC_GEN  = 0;
   localparam int unsigned SRC_H55  = 1;
   localparam int unsigned SRC_H65  = 2;
   localparam int unsigned SRC_H75  = 3;
   localparam int unsigned SRC_TRAP = 4;
   localparam int unsigned NMASK    = 4;

   localparam int unsigned SLOT_BYTES = 8;
   localparam int unsigned TRAP_VEC   = 'h24;

   function automatic int unsigned half_step_vec(input int unsigned slot);
      return slot * SLOT_BYTES + SLOT_BYTES / 2;
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture
   import irq_vec_pkg::*;
#(
   parameter cap_mode_e   MODE = CAP_EDGE,
   parameter int unsigned QUAL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic clr,
   output logic pend
);
   localparam int unsigned CW = $clog2(QUAL + 1);

   if (QUAL < 2) begin : g_bad_qual
      $error("irq_capture: QUAL must be at least 2");
   end

   if (MODE == CAP_LEVEL) begin : g_level
      logic unused_clr;
      assign unused_clr = clr;
      assign pend = line;
   end else if (MODE == CAP_EDGE) begin : g_edge
      logic prev_q, sticky_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q   <= 1'b0;
            sticky_q <= 1'b0;
         end else begin
            prev_q <= line;
            if (line && !prev_q) sticky_q <= 1'b1;
            else if (clr)        sticky_q <= 1'b0;
         end
      end
      assign pend = sticky_q;

      assert_sticky_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (sticky_q && !clr) |=> sticky_q);
   end else begin : g_hybrid
      logic          prev_q, armed_q, sticky_q;
      logic [CW-1:0] cnt_q;
      logic          qual_hit;

      assign qual_hit = armed_q && line && (cnt_q == CW'(QUAL - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q   <= 1'b0;
            armed_q  <= 1'b0;
            cnt_q    <= '0;
            sticky_q <= 1'b0;
         end else begin
            prev_q <= line;
            if (line && !prev_q) begin
               armed_q <= 1'b1;
               cnt_q   <= CW'(1);
            end else if (armed_q) begin
               if (!line || qual_hit) armed_q <= 1'b0;
               else                   cnt_q   <= cnt_q + CW'(1);
            end
            if (qual_hit)  sticky_q <= 1'b1;
            else if (clr)  sticky_q <= 1'b0;
         end
      end
      assign pend = sticky_q;

      assert_hybrid_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sticky_q) |-> ($past(line) && $past(line, 2)));
      assert_hybrid_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (sticky_q && !clr) |=> sticky_q);
   end
endmodule

// File: rtl/irq_select.sv
module irq_select
   import irq_vec_pkg::*;
#(
   parameter int unsigned VEC_W = 16
) (
   input  logic [NSRC-1:0]  elig,
   input  logic [7:0]       opcode,
   output logic [NSRC-1:0]  grant,
   output logic             any,
   output logic [VEC_W-1:0] vec,
   output logic             is_rst
);
   localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(TRAP_VEC);
   localparam logic [VEC_W-1:0] V_H55  = VEC_W'(half_step_vec(5));
   localparam logic [VEC_W-1:0] V_H65  = VEC_W'(half_step_vec(6));
   localparam logic [VEC_W-1:0] V_H75  = VEC_W'(half_step_vec(7));

   logic op_is_rst;
   assign op_is_rst = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b111);
   assign any = |elig;

   // higher index carries higher priority; last match wins
   always_comb begin
      grant = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (elig[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

   always_comb begin
      vec    = '0;
      is_rst = 1'b1;
      if (grant[SRC_TRAP])     vec = V_TRAP;
      else if (grant[SRC_H75]) vec = V_H75;
      else if (grant[SRC_H65]) vec = V_H65;
      else if (grant[SRC_H55]) vec = V_H55;
      else if (op_is_rst)      vec = VEC_W'({opcode[5:3], 3'b000});
      else                     is_rst = 1'b0;
   end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import irq_vec_pkg::*;
#(
   parameter int unsigned VEC_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_CYCLES = 4,
   parameter cap_mode_e   MODE_GEN    = CAP_LEVEL,
   parameter cap_mode_e   MODE_H55    = CAP_LEVEL,
   parameter cap_mode_e   MODE_H65    = CAP_LEVEL,
   parameter cap_mode_e   MODE_H75    = CAP_EDGE,
   parameter cap_mode_e   MODE_TRAP   = CAP_HYBRID
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_gen,
   input  logic [2:0]       req_hs,
   input  logic             req_trap,
   input  logic             ack,
   input  logic [7:0]       ack_opcode,
   input  logic             mask_wr,
   input  logic [3:0]       mask_wdata,
   input  logic             gie_set,
   output logic             irq_out,
   output logic [4:0]       pending,
   output logic [3:0]       mask_q,
   output logic             gie_q,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_addr,
   output logic             vec_is_rst
);
   if (VEC_W < 8) begin : g_bad_vec_w
      $error("irq_vector_unit: VEC_W must be at least 8");
   end

   logic [NSRC-1:0]  raw_req, sync_req, pend, elig, grant, clr;
   logic             any;
   logic [VEC_W-1:0] sel_vec;
   logic             sel_rst, take;

   assign raw_req = {req_trap, req_hs, req_gen};

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam cap_mode_e M = (i == SRC_TRAP) ? MODE_TRAP :
                                (i == SRC_H75)  ? MODE_H75  :
                                (i == SRC_H65)  ? MODE_H65  :
                                (i == SRC_H55)  ? MODE_H55  : MODE_GEN;
      irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(raw_req[i]), .q(sync_req[i]));
      irq_capture #(.MODE(M), .QUAL(QUAL_CYCLES)) u_cap (
         .clk(clk), .rst_n(rst_n), .line(sync_req[i]), .clr(clr[i]), .pend(pend[i]));
      if (i == SRC_TRAP) begin : g_nmi
         assign elig[i] = pend[i];
      end else begin : g_maskable
         assign elig[i] = pend[i] && !mask_q[i] && gie_q;
      end
   end

   irq_select #(.VEC_W(VEC_W)) u_sel (
      .elig(elig), .opcode(ack_opcode), .grant(grant), .any(any),
      .vec(sel_vec), .is_rst(sel_rst));

   assign take = ack && any;
   assign clr  = take ? grant : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '1;
         gie_q      <= 1'b0;
         vec_valid  <= 1'b0;
         vec_addr   <= '0;
         vec_is_rst <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= mask_wdata;
         if (take)         gie_q <= 1'b0;
         else if (gie_set) gie_q <= 1'b1;
         vec_valid <= take;
         if (take) begin
            vec_addr   <= sel_vec;
            vec_is_rst <= sel_rst;
         end
      end
   end

   assign irq_out = any;
   assign pending = pend;

   assert_trap_reaches_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pending[SRC_TRAP] |-> irq_out);
   assert_gate_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !pending[SRC_TRAP]) |-> gie_q);
   assert_enable_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> !gie_q);
   assert_strobe_follows_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(ack && irq_out));
endmodule

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_gen = 1'b0, req_trap = 1'b0, ack = 1'b0, mask_wr = 1'b0, gie_set = 1'b0;
   logic [2:0]  req_hs = '0;
   logic [7:0]  ack_opcode = '0;
   logic [3:0]  mask_wdata = '0;
   logic        irq_out, gie_q, vec_valid, vec_is_rst;
   logic [4:0]  pending;
   logic [3:0]  mask_q;
   logic [15:0] vec_addr;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   irq_vector_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_gen(req_gen), .req_hs(req_hs), .req_trap(req_trap),
      .ack(ack), .ack_opcode(ack_opcode), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .gie_set(gie_set), .irq_out(irq_out), .pending(pending), .mask_q(mask_q),
      .gie_q(gie_q), .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_is_rst(vec_is_rst));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mask(input logic [3:0] m);
      mask_wdata = m; mask_wr = 1'b1; cyc(1); mask_wr = 1'b0;
   endtask

   task automatic enable();
      gie_set = 1'b1; cyc(1); gie_set = 1'b0;
   endtask

   task automatic do_ack(input string tag, input logic [7:0] op, input bit exp_v,
                         input int exp_addr, input bit exp_rst);
      ack_opcode = op; ack = 1'b1; cyc(1); ack = 1'b0;
      check({tag, " strobe"}, vec_valid, exp_v);
      if (exp_v) begin
         check({tag, " addr"}, vec_addr, exp_addr);
         check({tag, " is_rst"}, vec_is_rst, exp_rst);
         check("R9 enable cleared by grant", gie_q, 0);
      end
      cyc(1);
      check("R10 strobe lasts one cycle", vec_valid, 0);
   endtask

   task automatic t_reset();
      check("R11 pending", pending, 0);
      check("R11 mask", mask_q, 4'hF);
      check("R11 enable", gie_q, 0);
      check("R11 irq_out", irq_out, 0);
      check("R11 vec_valid", vec_valid, 0);
   endtask

   task automatic t_level_sync();
      req_hs[0] = 1'b1; cyc(1);
      check("R1 not yet visible after one edge", pending[1], 0);
      cyc(1);
      check("R1 visible after two edges", pending[1], 1);
      cyc(3);
      check("R2 level held", pending[1], 1);
      req_hs[0] = 1'b0; cyc(2);
      check("R2 released", pending[1], 0);
   endtask

   task automatic t_edge_masked();
      req_hs[2] = 1'b1; cyc(1); req_hs[2] = 1'b0; cyc(5);
      check("R3 masked edge retained", pending[3], 1);
      check("R9 masked source no request", irq_out, 0);
      write_mask(4'b0111); cyc(1);
      check("R9 unmasked but enable low", irq_out, 0);
      enable();
      check("R9 unmasked and enabled", irq_out, 1);
      do_ack("R5 vector 7.5", 8'h00, 1, 'h3C, 1);
      check("R3 cleared by its ack", pending[3], 0);
   endtask

   task automatic t_hybrid();
      write_mask(4'hF);
      req_trap = 1'b1; cyc(3); req_trap = 1'b0; cyc(8);
      check("R4 short pulse rejected", pending[4], 0);
      check("R4 short pulse no request", irq_out, 0);
      req_trap = 1'b1; cyc(4); req_trap = 1'b0; cyc(8);
      check("R4 full pulse accepted", pending[4], 1);
      check("R8 trap ignores mask and enable", irq_out, 1);
      do_ack("R5 vector trap", 8'h00, 1, 'h24, 1);
      check("R4 cleared by ack", pending[4], 0);
   endtask

   task automatic t_priority();
      write_mask(4'h0);
      req_hs[0] = 1'b1; req_hs[1] = 1'b1; req_gen = 1'b1;
      req_hs[2] = 1'b1; req_trap = 1'b1; cyc(1); req_hs[2] = 1'b0;
      cyc(5); req_trap = 1'b0; cyc(4);
      check("R7 all pending", pending, 5'h1F);
      enable();
      do_ack("R7 trap first", 8'hEF, 1, 'h24, 1);
      enable();
      do_ack("R7 7.5 second", 8'hEF, 1, 'h3C, 1);
      enable();
      do_ack("R7 6.5 third", 8'hEF, 1, 'h34, 1);
      req_hs[1] = 1'b0; cyc(3);
      enable();
      do_ack("R7 5.5 fourth", 8'hEF, 1, 'h2C, 1);
      req_hs[0] = 1'b0; cyc(3);
      write_mask(4'h1); enable();
      check("R9 general masked", irq_out, 0);
      write_mask(4'h0);
      do_ack("R6 general RST5", 8'hEF, 1, 'h28, 1);
      enable();
      do_ack("R6 general RST0", 8'hC7, 1, 'h00, 1);
      enable();
      do_ack("R6 general RST7", 8'hFF, 1, 'h38, 1);
      enable();
      do_ack("R6 general non-restart", 8'hCD, 1, 'h00, 0);
      req_gen = 1'b0; cyc(3);
      enable();
      check("R10 nothing eligible", irq_out, 0);
      do_ack("R10 empty ack", 8'hEF, 0, 0, 0);
   endtask

   initial begin
      cyc(3); rst_n = 1'b1; cyc(1);
      t_reset();
      t_level_sync();
      t_edge_masked();
      t_hybrid();
      t_priority();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule